// File: doc/BRIEF.md
# Two-Level Composite Video Line Generator

This block produces the raster timing and pixel stream for monochrome composite video from a single clock that runs at a whole multiple of the pixel rate. A free-running horizontal counter defines each scan line. A line counter defines each frame. A small line-type register chooses the sync width for the coming line: a short horizontal pulse on ordinary lines, and a long pulse on a short run of lines near the top of the frame. The register is updated on the last clock of the previous line, so the width is settled well before the pulse can end.

On each visible line, a window opens a fixed delay after the line starts. The block fetches the line's pixels from a one-bit-per-pixel frame buffer as a burst of whole words and shifts them out most significant bit first. Each word is requested while the previous word is still shifting, so a line has no gaps between pixels. The two outputs, sync and video, feed an external resistor ladder. The frame buffer is a synchronous memory: it samples the address on a clock edge where the read strobe is high, and it presents the word after that same edge.

With the default parameters the clock equals a 5 MHz pixel clock. A line is 318 clocks (about 63.6 µs) and a frame is 262 lines. Horizontal sync is 24 clocks and the long sync is 136 clocks. Active video starts at clock 35 (7 µs) and is 256 pixels wide. The visible lines are 40 to 239.

Top module: `cvid_line_gen`

## Requirements
- R1: While rst is high, sync_o, video_o and fb_rd are all 0; the first clock after rst falls is clock 0 of line 0.
- R2: sync_o rises on clock 0 of every line, and lines repeat every LINE_CLKS clocks.
- R3: On lines outside the long-sync block, sync_o is 1 for exactly SYNC_CLKS clocks from line start, then 0 for the rest of the line.
- R4: On lines VSYNC_FIRST to VSYNC_FIRST+VSYNC_LINES-1, sync_o is 1 for exactly VSYNC_CLKS clocks from line start.
- R5: After line FRAME_LINES-1 the line number returns to 0, and the frame repeats with the same sync and video pattern.
- R6: On a visible line, video_o is 0 on every clock before VID_START and on every clock from VID_START+LINE_PIX*PIX_DIV onward.
- R7: On lines outside VIS_FIRST to VIS_FIRST+VIS_LINES-1, video_o and fb_rd stay 0 for the whole line.
- R8: In the window, pixel p (counted from 0) is held on video_o for PIX_DIV clocks starting at clock VID_START+p*PIX_DIV; it equals bit WORD_BITS-1-(p mod WORD_BITS) of word p/WORD_BITS, so the most significant bit goes out first and words follow with no gap.
- R9: On a visible line, fb_rd is 1 on exactly LINE_PIX/WORD_BITS clocks, VID_START+k*WORD_BITS*PIX_DIV-2 for k = 0 upward, with fb_addr = (line-VIS_FIRST)*(LINE_PIX/WORD_BITS)+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, PIX_DIV cycles per pixel |
| rst | input | 1 | Synchronous reset, active high |
| sync_o | output | 1 | Sync level, 1 during the sync pulse |
| video_o | output | 1 | Current pixel bit |
| fb_rd | output | 1 | Frame buffer read strobe |
| fb_addr | output | 11 | Frame buffer word address |
| fb_data | input | 32 | Frame buffer word, valid one clock after the read |

## Verification
The embedded properties assume that parameters are consistent: VID_START is at least 2, the window ends before the line ends, and a word spans more than one clock. The bench keeps the defaults, which meet all of these. It models the frame buffer as a one-cycle synchronous memory that answers every strobe. Word contents come from a seeded hash mixed with all-ones, all-zeros and end-bit patterns. A second reset lands at a random point in mid-frame, which confirms that the timing restarts cleanly from line 0.

// File: rtl/cvid_line_gen.sv
module cvid_line_gen #(
  parameter int PIX_DIV     = 1,
  parameter int LINE_CLKS   = 318,
  parameter int SYNC_CLKS   = 24,
  parameter int VSYNC_CLKS  = 136,
  parameter int VID_START   = 35,
  parameter int FRAME_LINES = 262,
  parameter int VSYNC_FIRST = 3,
  parameter int VSYNC_LINES = 3,
  parameter int VIS_FIRST   = 40,
  parameter int VIS_LINES   = 200,
  parameter int LINE_PIX    = 256,
  parameter int WORD_BITS   = 32,
  localparam int WORDS      = LINE_PIX / WORD_BITS,
  localparam int AW         = $clog2(VIS_LINES * WORDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic                 sync_o,
  output logic                 video_o,
  output logic                 fb_rd,
  output logic [AW-1:0]        fb_addr,
  input  logic [WORD_BITS-1:0] fb_data
);
  localparam int WPIX    = WORD_BITS * PIX_DIV;
  localparam int VID_END = VID_START + LINE_PIX * PIX_DIV;
  localparam int HW      = $clog2(LINE_CLKS);
  localparam int VW      = $clog2(FRAME_LINES);

  typedef enum logic {LT_NORM, LT_LONG} ltype_t;

  logic [HW-1:0]        hcnt;
  logic [VW-1:0]        vcnt;
  ltype_t               ltype;
  logic [WORD_BITS-1:0] sh;

  int  h, off1, off2;
  logic vis, ld, rd, in_win, step;

  function automatic ltype_t type_of(input logic [VW-1:0] v);
    return (int'(v) >= VSYNC_FIRST && int'(v) < VSYNC_FIRST + VSYNC_LINES) ? LT_LONG : LT_NORM;
  endfunction

  wire            line_end = (hcnt == HW'(LINE_CLKS - 1));
  wire            last_ln  = (vcnt == VW'(FRAME_LINES - 1));
  wire [VW-1:0]   vnext    = last_ln ? '0 : vcnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt  <= '0;
      vcnt  <= '0;
      ltype <= type_of('0);
    end else begin
      hcnt <= line_end ? '0 : hcnt + 1'b1;
      if (line_end) begin
        vcnt  <= vnext;
        ltype <= type_of(vnext);
      end
    end
  end

  assign sync_o = !rst && (int'(hcnt) < ((ltype == LT_LONG) ? VSYNC_CLKS : SYNC_CLKS));

  always_comb begin
    h      = int'(hcnt);
    off1   = h + 1 - VID_START;
    off2   = h + 2 - VID_START;
    vis    = int'(vcnt) >= VIS_FIRST && int'(vcnt) < VIS_FIRST + VIS_LINES;
    ld     = vis && off1 >= 0 && (off1 % WPIX) == 0 && (off1 / WPIX) < WORDS;
    rd     = vis && off2 >= 0 && (off2 % WPIX) == 0 && (off2 / WPIX) < WORDS;
    in_win = h >= VID_START && h < VID_END;
    step   = in_win && ((h - VID_START + 1) % PIX_DIV) == 0;
  end

  assign fb_rd   = !rst && rd;
  assign fb_addr = rd ? AW'((int'(vcnt) - VIS_FIRST) * WORDS + off2 / WPIX) : '0;

  always_ff @(posedge clk) begin
    if (rst)       sh <= '0;
    else if (ld)   sh <= fb_data;
    else if (step) sh <= sh << 1;
  end

  assign video_o = !rst && vis && in_win && sh[WORD_BITS-1];

  a_r2_sync_at_start: assert property (@(posedge clk) disable iff (rst)
    line_end |=> sync_o);
  a_r4_type_held: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> $stable(ltype));
  a_r5_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    (line_end && last_ln) |=> (vcnt == '0));
  a_r8_word0_fetched: assert property (@(posedge clk) disable iff (rst)
    (ld && off1 == 0) |-> $past(fb_rd));
  a_r9_rd_spaced: assert property (@(posedge clk) disable iff (rst)
    fb_rd |=> !fb_rd);
endmodule

// File: tb/cvid_line_gen_test.sv
module cvid_line_gen_test;
  localparam int LINE = 318, FRAME = 262, SYNC = 24, VSYNC = 136, VS = 35;
  localparam int PD = 1, PIX = 256, WB = 32, WORDS = 8;
  localparam int VSF = 3, VSN = 3, VF = 40, VN = 200;

  logic clk = 0, rst = 1;
  logic sync_o, video_o, fb_rd;
  logic [10:0] fb_addr;
  logic [31:0] fb_data = '0;
  int checks = 0, failures = 0, cyc = 0;
  int h = 0, v = 0;
  bit wrapped = 0, done = 0;
  logic [31:0] salt;

  cvid_line_gen uut (.clk(clk), .rst(rst), .sync_o(sync_o), .video_o(video_o),
    .fb_rd(fb_rd), .fb_addr(fb_addr), .fb_data(fb_data));

  always #2 clk = ~clk;

  function automatic logic [31:0] memf(input int a);
    if (a % 5 == 0)  return 32'hFFFF_FFFF;
    if (a % 7 == 3)  return 32'h0;
    if (a % 11 == 1) return 32'h8000_0001;
    return (a * 32'h9E37_79B1) ^ salt;
  endfunction

  always @(posedge clk) if (fb_rd) fb_data <= memf(int'(fb_addr));

  function automatic bit vis_l(input int vv);
    return vv >= VF && vv < VF + VN;
  endfunction

  function automatic bit exp_video(input int hh, input int vv);
    int p;
    logic [31:0] w;
    if (!vis_l(vv) || hh < VS || hh >= VS + PIX * PD) return 1'b0;
    p = (hh - VS) / PD;
    w = memf((vv - VF) * WORDS + p / WB);
    return w[31 - (p % WB)];
  endfunction

  function automatic bit exp_rd(input int hh, input int vv);
    int o = hh + 2 - VS;
    return vis_l(vv) && o >= 0 && (o % (WB * PD)) == 0 && o / (WB * PD) < WORDS;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s line=%0d clk=%0d actual=%0d expected=%0d", req, v, h, act, exp);
    end
  endtask

  task automatic check_cycle();
    int sw;
    bit lng = (v >= VSF && v < VSF + VSN);
    sw = lng ? VSYNC : SYNC;
    if (h == 0)              chk("R2 sync start", sync_o, 1);
    else if (v == 0 && wrapped) chk("R5 sync after wrap", sync_o, int'(h < sw));
    else if (lng)            chk("R4 long sync", sync_o, int'(h < sw));
    else                     chk("R3 normal sync", sync_o, int'(h < sw));
    if (!vis_l(v)) begin
      chk("R7 video off line", video_o, 0);
      chk("R7 no read", fb_rd, 0);
    end else begin
      if (h < VS || h >= VS + PIX * PD) chk("R6 video outside window", video_o, 0);
      else chk("R8 pixel", video_o, exp_video(h, v));
      chk("R9 read strobe", fb_rd, exp_rd(h, v));
      if (exp_rd(h, v))
        chk("R9 read address", fb_addr, (v - VF) * WORDS + (h + 2 - VS) / (WB * PD));
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      check_cycle();
      @(negedge clk);
      if (h == LINE - 1) begin
        h = 0;
        if (v == FRAME - 1) begin v = 0; wrapped = 1; end
        else v++;
      end else h++;
    end
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) begin
      @(negedge clk);
      chk("R1 reset sync", sync_o, 0);
      chk("R1 reset video", video_o, 0);
      chk("R1 reset read", fb_rd, 0);
    end
    rst = 0;
    #1;
    h = 0; v = 0; wrapped = 0;
  endtask

  initial begin
    salt = $urandom(32'd7);
    salt = $urandom();
    do_reset();
    run(LINE * FRAME + 2 * LINE);
    run(($urandom() % 20000) + 100);
    do_reset();
    chk("R1 first clock is line 0 clock 0", sync_o, 1);
    run(VF * LINE + 3 * LINE);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      failures++;
      done = 1;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule